// File: doc/BRIEF.md
# Sound Generator Host Bus Register Interface

This block sits between a host processor's 8-bit parallel bus and the tone, noise and envelope logic of a three-channel sound generator. The host drives two asynchronous strobes: a select strobe and a direction strobe. From their combination the block decides whether to capture a register number from the bus, store a data byte into the selected register, or return the selected register's contents to the host. A third bus mode strobe found on some hosts is not decoded; the block acts as if it were always high.

A sixteen-entry register image is exported in flattened form to the sound-generation logic. That logic reads the image at any time, with no locking between host updates and the consumer. A write to the envelope shape register (register 13) also raises a one-cycle restart pulse for the envelope generator.

The physical pad is kept outside the block. It receives the incoming bus value on `bus_in`, and it drives `bus_out` onto the pins while `bus_oe` is high; otherwise the pins float. Read data comes from a holding register. That register is loaded when an address is captured and refreshed when the captured register is written.

Top module: `psg_bus_regfile`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all sixteen registers and the captured address clear to zero, and `bus_oe`, `bus_out` and `env_restart` are 0.
- R2: Select=1 with direction=1 captures the register number from `bus_in[3:0]`. Bits 7..4 are ignored.
- R3: Select=0 with direction=1 stores `bus_in` into the register at the captured address. Register n appears on `reg_image[8n+7:8n]`.
- R4: Select=1 with direction=0 raises `bus_oe` and presents the captured register's value on `bus_out` for as long as the mode lasts. `bus_oe` falls after select falls. `bus_out` is 0 whenever `bus_oe` is 0.
- R5: Select=0 with direction=0 is idle: `bus_oe` stays 0 and no register changes, whatever `bus_in` carries.
- R6: Each action takes effect at the fourth rising clock edge after the strobes change. Before that edge, the outputs still show the previous state.
- R7: A strobe combination that is present for only one clock cycle is ignored. This covers skew while both strobes change.
- R8: A write to register 13 raises `env_restart` for exactly one clock cycle. A write to any other register leaves it low.
- R9: The captured address persists, so repeated writes without a new capture all go to the same register.
- R10: After a write, a read with no new capture returns the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_sel | input | 1 | Asynchronous select strobe from host |
| ctl_dir | input | 1 | Asynchronous direction strobe from host |
| bus_in | input | 8 | Data bus value seen at the pad |
| bus_out | output | 8 | Read data to drive onto the pad |
| bus_oe | output | 1 | Pad output enable (read mode active) |
| reg_image | output | 128 | Flattened register image, register n in bits 8n+7..8n |
| env_restart | output | 1 | One-cycle pulse on a write to register 13 |

## Verification
Every result is due at the fourth rising edge after the strobe change that causes it. The path is two synchronizer flops, one stability sample, and then the committed mode or register update. The restart pulse is high only during the cycle after that edge. The driver changes strobes on a falling edge, waits four rising edges, and only then queues its expectations, which the monitor compares at the next falling edge. One latency case also queues an expectation after three edges to confirm the old state is still visible. Single-cycle strobe glitches are followed by several idle cycles before the register image and output enable are checked.

// File: rtl/psg_bus_pkg.sv
// Shared types for the sound generator host bus interface.
// Assumes the bus mode is formed as {select, direction}.
package psg_bus_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_READ  = 2'b10,
        MODE_LATCH = 2'b11
    } bus_mode_e;
endpackage

// File: rtl/psg_strobe_sync.sv
// Multi-stage synchronizer for asynchronous host strobes.
// Assumes each strobe is a level that is held for several clock cycles.
module psg_strobe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // shift the raw strobes through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/psg_mode_decode.sv
// Turns synchronized strobes into bus events.
// A mode is committed only after two equal consecutive samples, which filters
// single-cycle combinations seen while the strobes are in transit.
module psg_mode_decode
    import psg_bus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic dir_s,
    output logic lat_ev,
    output logic wr_ev,
    output logic rd_active
);
    bus_mode_e samp, prev_q, cur_q;
    logic      settle, change;

    assign samp   = bus_mode_e'({sel_s, dir_s});
    assign settle = (samp == prev_q);
    assign change = settle && (samp != cur_q);

    // remember the previous sample and the committed mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= MODE_IDLE;
            cur_q  <= MODE_IDLE;
        end else begin
            prev_q <= samp;
            if (change) cur_q <= samp;
        end
    end

    assign lat_ev    = change && (samp == MODE_LATCH);
    assign wr_ev     = change && (samp == MODE_WRITE);
    assign rd_active = (cur_q == MODE_READ);

    // R7
    stable_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_ev || wr_ev) |-> ($past(sel_s) == sel_s && $past(dir_s) == dir_s));
endmodule

// File: rtl/psg_reg_image.sv
// Sixteen-entry register image, captured address and read holding register.
// Assumes bus_in is stable at the cycle an event fires (host holds data
// for the whole strobe).
module psg_reg_image #(
    parameter int NREG    = 16,
    parameter int DW      = 8,
    parameter int ENV_REG = 13,
    localparam int AW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_ev,
    input  logic              wr_ev,
    input  logic [DW-1:0]     bus_in,
    output logic [NREG*DW-1:0] image,
    output logic [DW-1:0]     hold,
    output logic              env_pulse
);
    localparam logic [AW-1:0] ENV_IDX = AW'(ENV_REG);

    logic [DW-1:0] regs_q [NREG];
    logic [AW-1:0] addr_q;
    logic [AW-1:0] new_addr;

    assign new_addr = bus_in[AW-1:0];

    // capture the register number on a latch event
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (lat_ev) addr_q <= new_addr;
    end

    // store write data into the addressed entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_ev) begin
            regs_q[addr_q] <= bus_in;
        end
    end

    // prefetch on capture, refresh when the captured entry is written
    always_ff @(posedge clk) begin
        if (!rst_n)      hold <= '0;
        else if (lat_ev) hold <= regs_q[new_addr];
        else if (wr_ev)  hold <= bus_in;
    end

    // one-cycle envelope restart after a shape register write
    always_ff @(posedge clk) begin
        if (!rst_n) env_pulse <= 1'b0;
        else        env_pulse <= wr_ev && (addr_q == ENV_IDX);
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_flat
            assign image[g*DW +: DW] = regs_q[g];
        end
    endgenerate

    // R2
    addr_only_on_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q != $past(addr_q)) |-> $past(lat_ev));
    // R8
    env_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        env_pulse |=> !env_pulse);
endmodule

// File: rtl/psg_bus_regfile.sv
// Top of the host bus register interface: synchronizer, mode decode and
// register image. Assumes an external pad drives bus_out when bus_oe is high.
module psg_bus_regfile #(
    parameter int NREG    = 16,
    parameter int DW      = 8,
    parameter int SYNC    = 2,
    parameter int ENV_REG = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_sel,
    input  logic               ctl_dir,
    input  logic [DW-1:0]      bus_in,
    output logic [DW-1:0]      bus_out,
    output logic               bus_oe,
    output logic [NREG*DW-1:0] reg_image,
    output logic               env_restart
);
    logic [1:0]    strobe_s;
    logic          lat_ev, wr_ev, rd_active;
    logic [DW-1:0] hold;

    psg_strobe_sync #(.WIDTH(2), .STAGES(SYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ctl_sel, ctl_dir}),
        .sync_o  (strobe_s)
    );

    psg_mode_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (strobe_s[1]),
        .dir_s     (strobe_s[0]),
        .lat_ev    (lat_ev),
        .wr_ev     (wr_ev),
        .rd_active (rd_active)
    );

    psg_reg_image #(.NREG(NREG), .DW(DW), .ENV_REG(ENV_REG)) u_img (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_ev    (lat_ev),
        .wr_ev     (wr_ev),
        .bus_in    (bus_in),
        .image     (reg_image),
        .hold      (hold),
        .env_pulse (env_restart)
    );

    assign bus_oe  = rd_active;
    assign bus_out = rd_active ? hold : '0;

    // R4
    read_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_out));
    // R4
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));
endmodule

// File: tb/psg_bus_regfile_test.sv
module psg_bus_regfile_test;
    localparam int CLK_PERIOD = 37;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel = 1'b0, dir = 1'b0;
    logic [7:0]   din = '0;
    logic [7:0]   bus_out;
    logic         bus_oe;
    logic [127:0] reg_image;
    logic         env_restart;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        int          sel_obs;   // 0 bus_out, 1 bus_oe, 2 env_restart, 3 image byte
        int          idx;
        logic [7:0]  exp;
    } item_t;
    item_t q[$];

    logic [7:0] model [16];
    int         cur_addr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psg_bus_regfile uut (
        .clk(clk), .rst_n(rst_n), .ctl_sel(sel), .ctl_dir(dir),
        .bus_in(din), .bus_out(bus_out), .bus_oe(bus_oe),
        .reg_image(reg_image), .env_restart(env_restart)
    );

    function automatic logic [7:0] observe(int s, int idx);
        case (s)
            0: return bus_out;
            1: return {7'd0, bus_oe};
            2: return {7'd0, env_restart};
            default: return reg_image[8*idx +: 8];
        endcase
    endfunction

    // monitor: compare every queued expectation at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = q.pop_front();
                got = observe(it.sel_obs, it.idx);
                total++;
                if (got !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic expect_val(string tag, int s, int idx, logic [7:0] e);
        item_t it;
        it.tag = tag; it.sel_obs = s; it.idx = idx; it.exp = e;
        q.push_back(it);
    endtask

    task automatic drive(logic b1, logic bd, logic [7:0] d, int edges);
        @(negedge clk);
        sel = b1; dir = bd; din = d;
        repeat (edges) @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        drive(1'b0, 1'b0, 8'h00, 4);
    endtask

    task automatic latch(logic [7:0] a);
        drive(1'b1, 1'b1, a, 4);
        cur_addr = int'(a[3:0]);
        go_idle();
    endtask

    task automatic write(logic [7:0] v, string tag);
        drive(1'b0, 1'b1, v, 4);
        model[cur_addr] = v;
        expect_val({tag, " image"}, 3, cur_addr, v);
        expect_val({tag, " R8 env pulse"}, 2, 0, (cur_addr == 13) ? 8'd1 : 8'd0);
        @(posedge clk); #1;
        expect_val({tag, " R8 env low after one cycle"}, 2, 0, 8'd0);
        go_idle();
    endtask

    task automatic read(string tag);
        drive(1'b1, 1'b0, 8'h00, 4);
        expect_val({tag, " oe"}, 1, 0, 8'd1);
        expect_val({tag, " data"}, 0, 0, model[cur_addr]);
        go_idle();
        expect_val({tag, " R4 oe released"}, 1, 0, 8'd0);
        expect_val({tag, " R4 data zero"}, 0, 0, 8'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        expect_val("R1 oe", 1, 0, 8'd0);
        expect_val("R1 data", 0, 0, 8'd0);
        expect_val("R1 env", 2, 0, 8'd0);
        for (int i = 0; i < 16; i += 5) expect_val("R1 image", 3, i, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 basic capture and write
        latch(8'h03);
        write(8'hA5, "R3 reg3");
        read("R4 reg3");

        // R2 upper bits ignored, R8 pulse on register 13
        latch(8'h2D);
        write(8'h0E, "R8 reg13");
        read("R2 upper bits ignored");

        // R9 repeated writes without recapture
        latch(8'h07);
        write(8'h11, "R9 first");
        write(8'h22, "R9 second");
        expect_val("R9 neighbour untouched", 3, 8, 8'h00);
        read("R9 last write wins");

        // R10 write then read with no new capture
        latch(8'h05);
        write(8'h5C, "R10 write");
        read("R10 read back");

        // R6 latency: old state after three edges, new after four
        latch(8'h03);
        cur_addr = 3;
        drive(1'b1, 1'b0, 8'h00, 3);
        expect_val("R6 oe not yet", 1, 0, 8'd0);
        @(posedge clk); #1;
        expect_val("R6 oe at fourth edge", 1, 0, 8'd1);
        expect_val("R6 data at fourth edge", 0, 0, 8'hA5);
        go_idle();

        // R7 one-cycle write glitch is ignored
        drive(1'b0, 1'b1, 8'hFF, 1);
        drive(1'b0, 1'b0, 8'h00, 6);
        expect_val("R7 write glitch", 3, 3, 8'hA5);
        expect_val("R7 no env", 2, 0, 8'd0);
        // R7 one-cycle read glitch never enables the bus
        drive(1'b1, 1'b0, 8'h00, 1);
        expect_val("R7 read glitch oe", 1, 0, 8'd0);
        drive(1'b0, 1'b0, 8'h00, 3);
        expect_val("R7 read glitch oe later", 1, 0, 8'd0);

        // R5 idle ignores bus activity
        drive(1'b0, 1'b0, 8'h77, 8);
        expect_val("R5 oe idle", 1, 0, 8'd0);
        expect_val("R5 reg3 unchanged", 3, 3, 8'hA5);
        expect_val("R5 reg7 unchanged", 3, 7, 8'h22);

        // top register boundary
        latch(8'h0F);
        write(8'hFF, "R3 reg15");
        read("R4 reg15");
        expect_val("R3 reg13 kept", 3, 13, 8'h0E);

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule